// File: doc/BRIEF.md
# SDR SDRAM Command Encoder with Mask Alignment

This block sits at the pin edge of a synchronous DRAM controller. Each clock it takes at most one abstract request and turns it into a single registered command cycle on the memory pins. The requests are row open, column read, column write, burst stop, precharge, auto refresh, self-refresh entry, self-refresh exit and mode-register load. For each one it drives the chip select, the three strobe lines, the clock enable, the bank pins and the twelve address pins. It fills in row, column, bank and op-code fields and sets the dual-purpose bit A10. When no request is pending, the block issues a no-operation.

The block also drives the byte mask (DQM) for the data bus. The scheduler hands it one mask per data beat, three cycles before that beat occupies the bus, and says whether the beat is read or write data. The device samples the write mask in the data cycle itself, but acts on the read mask two clocks early. The block therefore delays write masks and forwards read masks at once, so that both land where the device expects them.

Top module: `sdram_cmd_enc`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pins show an inhibit: CS# high, RAS#/CAS#/WE# high, CKE high, BA and A zero, DQM zero. req_ready is low during reset.
- R2: A cycle with no accepted request, outside self refresh, drives a no-operation on the pins: CS#,RAS#,CAS#,WE# = 0,1,1,1, CKE high, BA and A zero.
- R3: Request codes on req_op are: 0 open row, 1 read, 2 write, 3 burst stop, 4 precharge, 5 auto refresh, 6 self-refresh entry, 7 mode load, 8 self-refresh exit. CS#,RAS#,CAS#,WE# are 0011 for open row, 0101 for read, 0100 for write, 0110 for burst stop, 0010 for precharge, 0001 for either refresh, and 0000 for mode load.
- R4: Open row puts req_row on A11..A0 and req_bank on BA1..BA0.
- R5: Read and write put the column on the low A bits, and the field width follows DATA_W: 10 bits for 4, 9 bits for 8, 8 bits for 16. Column bits above the field are dropped. The A bits outside the field other than A10 are driven low, and BA carries req_bank.
- R6: On read and write, A10 equals req_autopre, chosen separately for each command.
- R7: On precharge, A10 equals req_allbanks. With A10 low, BA carries req_bank. With A10 high, BA is driven zero.
- R8: Auto refresh drives the refresh code with CKE high. Self-refresh entry drives the same code with CKE low. All other commands keep CKE high.
- R9: After self-refresh entry, CKE stays low and CS# stays high. req_ready is low for every code except self-refresh exit, so other requests are not taken. An exit request drives a no-operation with CKE high, and ready then returns.
- R10: Mode load places req_opcode on A11..A0 and zero on BA.
- R11: A read-beat mask given with dm_valid and dm_is_read appears on DQM one cycle later, which is two clocks ahead of its data beat.
- R12: A write-beat mask given with dm_valid and dm_is_read low appears on DQM three cycles later, in the cycle of its data beat. When read and write masks coincide on the pins they are ORed, and with no mask DQM is zero.
- R13: Outside self refresh req_ready is high. Each accepted request produces exactly one command cycle, on the clock edge where it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 4 | Request code (see R3) |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address for open row |
| req_col | input | 10 | Column address for read/write |
| req_autopre | input | 1 | Auto-precharge after burst |
| req_allbanks | input | 1 | Precharge every bank |
| req_opcode | input | 12 | Mode register value |
| dm_valid | input | 1 | Beat mask present |
| dm_is_read | input | 1 | Beat mask belongs to read data |
| dm_mask | input | DATA_W/8 (min 1) | Beat byte mask, 1 masks |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address pins |
| sd_dqm | output | DATA_W/8 (min 1) | Data byte mask |

## Verification
The bench drives A10 in all four of its roles: auto-precharge on and off for reads and writes, single-bank precharge and all-bank precharge. A design that confused the flags would leave the wrong bank open or lose one. It writes a column with every bit set, so that a field wider than the device's column count shows up as stray high address bits. Self refresh is tested by offering an open-row request while CKE is low. A design that took that request would wake the device, or issue a command it cannot see. Read and write masks are sent separately and tracked cycle by cycle. If the two paths shared one latency, one of them would land a cycle early or late and mask the wrong byte.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    localparam int SD_ADDR_W = 12;
    localparam int SD_BA_W   = 2;
    localparam int COL_IN_W  = 10;
    localparam int AP_BIT    = 10;
    localparam int OP_W      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ACT  = 4'd0,
        OP_RD   = 4'd1,
        OP_WR   = 4'd2,
        OP_BST  = 4'd3,
        OP_PRE  = 4'd4,
        OP_REF  = 4'd5,
        OP_SELF = 4'd6,
        OP_MRS  = 4'd7,
        OP_SRX  = 4'd8
    } req_op_e;

    // Strobe group, all active low: chip select, row, column, write.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_INH = 4'b1111;
    localparam cmd_pins_t CMD_NOP = 4'b0111;
    localparam cmd_pins_t CMD_ACT = 4'b0011;
    localparam cmd_pins_t CMD_RD  = 4'b0101;
    localparam cmd_pins_t CMD_WR  = 4'b0100;
    localparam cmd_pins_t CMD_BST = 4'b0110;
    localparam cmd_pins_t CMD_PRE = 4'b0010;
    localparam cmd_pins_t CMD_REF = 4'b0001;
    localparam cmd_pins_t CMD_MRS = 4'b0000;

    typedef struct packed {
        cmd_pins_t              cmd;
        logic                   cke;
        logic [SD_BA_W-1:0]     ba;
        logic [SD_ADDR_W-1:0]   addr;
    } pin_bus_t;

    localparam pin_bus_t PINS_RESET = '{cmd: CMD_INH, cke: 1'b1, ba: '0, addr: '0};
    localparam pin_bus_t PINS_NOP   = '{cmd: CMD_NOP, cke: 1'b1, ba: '0, addr: '0};
    localparam pin_bus_t PINS_SLEEP = '{cmd: CMD_INH, cke: 1'b0, ba: '0, addr: '0};

    function automatic int col_bits(input int data_w);
        if (data_w <= 4)      return 10;
        else if (data_w <= 8) return 9;
        else                  return 8;
    endfunction

    function automatic int mask_bits(input int data_w);
        return (data_w < 8) ? 1 : data_w / 8;
    endfunction

endpackage

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
    import sdram_cmd_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  valid,
    input  req_op_e               op,
    input  logic [SD_BA_W-1:0]    bank,
    input  logic [SD_ADDR_W-1:0]  row,
    input  logic [COL_IN_W-1:0]   col,
    input  logic                  autopre,
    input  logic                  allbanks,
    input  logic [SD_ADDR_W-1:0]  opcode,
    output pin_bus_t              pins
);

    logic [SD_ADDR_W-1:0] col_field;

    always_comb begin
        col_field             = '0;
        col_field[COL_W-1:0]  = col[COL_W-1:0];
    end

    always_comb begin
        pins = PINS_NOP;
        if (valid) begin
            case (op)
                OP_ACT: begin
                    pins.cmd  = CMD_ACT;
                    pins.ba   = bank;
                    pins.addr = row;
                end
                OP_RD, OP_WR: begin
                    pins.cmd          = (op == OP_RD) ? CMD_RD : CMD_WR;
                    pins.ba           = bank;
                    pins.addr         = col_field;
                    pins.addr[AP_BIT] = autopre;
                end
                OP_BST: pins.cmd = CMD_BST;
                OP_PRE: begin
                    pins.cmd          = CMD_PRE;
                    pins.addr[AP_BIT] = allbanks;
                    pins.ba           = allbanks ? '0 : bank;
                end
                OP_REF: pins.cmd = CMD_REF;
                OP_SELF: begin
                    pins.cmd = CMD_REF;
                    pins.cke = 1'b0;
                end
                OP_MRS: begin
                    pins.cmd  = CMD_MRS;
                    pins.addr = opcode;
                end
                default: pins = PINS_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_dqm_align.sv
module sdram_dqm_align #(
    parameter int DQM_W  = 2,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dm_valid,
    input  logic             dm_is_read,
    input  logic [DQM_W-1:0] dm_mask,
    output logic [DQM_W-1:0] dqm
);

    logic [DQM_W-1:0] rd_now;
    logic [DQM_W-1:0] wr_in;
    logic [DQM_W-1:0] wr_due;

    assign rd_now = (dm_valid &&  dm_is_read) ? dm_mask : '0;
    assign wr_in  = (dm_valid && !dm_is_read) ? dm_mask : '0;

    // Write masks wait out the read lead so they meet their own beat.
    generate
        if (RD_LAT == 0) begin : g_no_delay
            assign wr_due = wr_in;
        end else begin : g_delay
            logic [DQM_W-1:0] stage [RD_LAT];
            for (genvar i = 0; i < RD_LAT; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)         stage[i] <= '0;
                    else if (i == 0) stage[i] <= wr_in;
                    else             stage[i] <= stage[(i == 0) ? 0 : i-1];
                end
            end
            assign wr_due = stage[RD_LAT-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) dqm <= '0;
        else     dqm <= rd_now | wr_due;
    end

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_cmd_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DQM_RD_LAT = 2,
    localparam int DQM_W     = mask_bits(DATA_W),
    localparam int COL_W     = col_bits(DATA_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [OP_W-1:0]       req_op,
    input  logic [SD_BA_W-1:0]    req_bank,
    input  logic [SD_ADDR_W-1:0]  req_row,
    input  logic [COL_IN_W-1:0]   req_col,
    input  logic                  req_autopre,
    input  logic                  req_allbanks,
    input  logic [SD_ADDR_W-1:0]  req_opcode,
    input  logic                  dm_valid,
    input  logic                  dm_is_read,
    input  logic [DQM_W-1:0]      dm_mask,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic                  sd_cke,
    output logic [SD_BA_W-1:0]    sd_ba,
    output logic [SD_ADDR_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]      sd_dqm
);

    req_op_e  op;
    logic     in_sleep;
    logic     take;
    pin_bus_t mux_pins;
    pin_bus_t next_pins;
    pin_bus_t pins_q;

    assign op        = req_op_e'(req_op);
    assign req_ready = !rst && (!in_sleep || op == OP_SRX);
    assign take      = req_valid && req_ready;

    sdram_addr_mux #(.COL_W(COL_W)) i_addr_mux (
        .valid    (take),
        .op       (op),
        .bank     (req_bank),
        .row      (req_row),
        .col      (req_col),
        .autopre  (req_autopre),
        .allbanks (req_allbanks),
        .opcode   (req_opcode),
        .pins     (mux_pins)
    );

    always_comb begin
        if (in_sleep && !take) next_pins = PINS_SLEEP;
        else                   next_pins = mux_pins;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q   <= PINS_RESET;
            in_sleep <= 1'b0;
        end else begin
            pins_q <= next_pins;
            if (take && op == OP_SELF)     in_sleep <= 1'b1;
            else if (take && op == OP_SRX) in_sleep <= 1'b0;
        end
    end

    sdram_dqm_align #(.DQM_W(DQM_W), .RD_LAT(DQM_RD_LAT)) i_dqm_align (
        .clk        (clk),
        .rst        (rst),
        .dm_valid   (dm_valid),
        .dm_is_read (dm_is_read),
        .dm_mask    (dm_mask),
        .dqm        (sd_dqm)
    );

    assign sd_cs_n  = pins_q.cmd.cs_n;
    assign sd_ras_n = pins_q.cmd.ras_n;
    assign sd_cas_n = pins_q.cmd.cas_n;
    assign sd_we_n  = pins_q.cmd.we_n;
    assign sd_cke   = pins_q.cke;
    assign sd_ba    = pins_q.ba;
    assign sd_addr  = pins_q.addr;

endmodule

// File: rtl/sdram_cmd_enc_chk.sv
module sdram_cmd_enc_chk
    import sdram_cmd_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DQM_RD_LAT = 2,
    localparam int DQM_W     = mask_bits(DATA_W)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [OP_W-1:0]      req_op,
    input logic [SD_BA_W-1:0]   req_bank,
    input logic [SD_ADDR_W-1:0] req_row,
    input logic                 req_autopre,
    input logic                 req_allbanks,
    input logic                 dm_valid,
    input logic                 dm_is_read,
    input logic [DQM_W-1:0]     dm_mask,
    input logic                 sd_cs_n,
    input logic                 sd_ras_n,
    input logic                 sd_cas_n,
    input logic                 sd_we_n,
    input logic                 sd_cke,
    input logic [SD_BA_W-1:0]   sd_ba,
    input logic [SD_ADDR_W-1:0] sd_addr,
    input logic [DQM_W-1:0]     sd_dqm
);

    logic [3:0] strobes;
    logic       take;
    logic [1:0] since_rst;

    assign strobes = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign take    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    assert_act_fields_R4: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_ACT) |=>
            (strobes == 4'b0011 && sd_addr == $past(req_row) && sd_ba == $past(req_bank)));

    assert_read_ap_R6: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_RD) |=>
            (strobes == 4'b0101 && sd_addr[AP_BIT] == $past(req_autopre)));

    assert_pre_all_R7: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_PRE && req_allbanks) |=>
            (strobes == 4'b0010 && sd_addr[AP_BIT] && sd_ba == '0));

    assert_self_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_SELF) |=> (!sd_cke && strobes == 4'b0001));

    assert_cke_low_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (sd_cs_n || strobes == 4'b0001));

    assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (!sd_cke && req_op != OP_SRX) |-> !req_ready);

    assert_rd_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (dm_valid && dm_is_read) |=> ((sd_dqm & $past(dm_mask)) == $past(dm_mask)));

    generate
        if (DQM_RD_LAT == 2) begin : g_wr_chk
            assert_wr_mask_R12: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 3 && $past(dm_valid && !dm_is_read, 3)) |->
                    ((sd_dqm & $past(dm_mask, 3)) == $past(dm_mask, 3)));
        end
    endgenerate

endmodule

bind sdram_cmd_enc sdram_cmd_enc_chk #(.DATA_W(DATA_W), .DQM_RD_LAT(DQM_RD_LAT)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .req_autopre  (req_autopre),
    .req_allbanks (req_allbanks),
    .dm_valid     (dm_valid),
    .dm_is_read   (dm_is_read),
    .dm_mask      (dm_mask),
    .sd_cs_n      (sd_cs_n),
    .sd_ras_n     (sd_ras_n),
    .sd_cas_n     (sd_cas_n),
    .sd_we_n      (sd_we_n),
    .sd_cke       (sd_cke),
    .sd_ba        (sd_ba),
    .sd_addr      (sd_addr),
    .sd_dqm       (sd_dqm)
);

// File: tb/test_sdram_cmd_enc.sv
module test_sdram_cmd_enc;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_autopre = 1'b0;
    logic        req_allbanks = 1'b0;
    logic [11:0] req_opcode = '0;
    logic        dm_valid = 1'b0;
    logic        dm_is_read = 1'b0;
    logic [1:0]  dm_mask = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    sdram_cmd_enc i_sdram_cmd_enc (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .req_allbanks(req_allbanks), .req_opcode(req_opcode),
        .dm_valid(dm_valid), .dm_is_read(dm_is_read), .dm_mask(dm_mask),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_cke(sd_cke), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    function automatic logic [3:0] strobes();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, then return just after the edge that takes it.
    task automatic issue(input logic [3:0] op, input logic [1:0] bank, input logic [11:0] row,
                         input logic [9:0] col, input logic ap, input logic all,
                         input logic [11:0] opc);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank = bank; req_row = row; req_col = col;
        req_autopre = ap; req_allbanks = all; req_opcode = opc;
        @(posedge clk); #1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0; dm_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready low in reset", req_ready, 0);
        chk("R1 strobes in reset", strobes(), 4'b1111);
        chk("R1 cke/ba/addr/dqm in reset", {sd_cke, sd_ba, sd_addr, sd_dqm}, {1'b1, 2'b0, 12'h0, 2'b0});
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R2 idle gives nop", {strobes(), sd_cke, sd_ba, sd_addr}, {4'b0111, 1'b1, 2'b0, 12'h0});
        chk("R13 ready high when awake", req_ready, 1);
    endtask

    task automatic t_activate();
        issue(4'd0, 2'd2, 12'hA5C, 10'h0, 1'b0, 1'b0, 12'h0);
        chk("R3 open-row code", strobes(), 4'b0011);
        chk("R4 row and bank", {sd_ba, sd_addr}, {2'd2, 12'hA5C});
        idle_cycle();
        chk("R13 single command then nop", strobes(), 4'b0111);
    endtask

    task automatic t_read_write();
        issue(4'd1, 2'd1, 12'h0, 10'h3FF, 1'b1, 1'b0, 12'h0);
        chk("R3 read code", strobes(), 4'b0101);
        chk("R5 column width 8 for x16", {sd_ba, sd_addr}, {2'd1, 12'h4FF});
        chk("R6 read autopre on", sd_addr[10], 1);
        issue(4'd2, 2'd3, 12'h0, 10'h05A, 1'b0, 1'b0, 12'h0);
        chk("R3 write code back-to-back", strobes(), 4'b0100);
        chk("R6 write autopre off", {sd_ba, sd_addr}, {2'd3, 12'h05A});
        issue(4'd2, 2'd0, 12'h0, 10'h2C3, 1'b1, 1'b0, 12'h0);
        chk("R5 R6 write drops high column bits", sd_addr, 12'h4C3);
        idle_cycle();
    endtask

    task automatic t_precharge();
        issue(4'd4, 2'd3, 12'hFFF, 10'h3FF, 1'b1, 1'b0, 12'hFFF);
        chk("R7 single bank", {strobes(), sd_ba, sd_addr}, {4'b0010, 2'd3, 12'h000});
        issue(4'd4, 2'd3, 12'h0, 10'h0, 1'b0, 1'b1, 12'h0);
        chk("R7 all banks", {strobes(), sd_ba, sd_addr}, {4'b0010, 2'd0, 12'h400});
        idle_cycle();
    endtask

    task automatic t_misc_cmds();
        issue(4'd3, 2'd1, 12'h123, 10'h1, 1'b1, 1'b1, 12'h0);
        chk("R3 burst stop", {strobes(), sd_ba, sd_addr}, {4'b0110, 2'd0, 12'h0});
        issue(4'd5, 2'd1, 12'h123, 10'h1, 1'b0, 1'b0, 12'h0);
        chk("R8 auto refresh cke high", {strobes(), sd_cke}, {4'b0001, 1'b1});
        issue(4'd7, 2'd2, 12'h0, 10'h0, 1'b0, 1'b0, 12'h237);
        chk("R10 mode load", {strobes(), sd_ba, sd_addr}, {4'b0000, 2'd0, 12'h237});
        idle_cycle();
    endtask

    task automatic t_self_refresh();
        issue(4'd6, 2'd0, 12'h0, 10'h0, 1'b0, 1'b0, 12'h0);
        chk("R8 self entry", {strobes(), sd_cke}, {4'b0001, 1'b0});
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd0; req_row = 12'h777; req_bank = 2'd1;
        #1;
        chk("R9 ready low for open row", req_ready, 0);
        @(posedge clk); #1;
        chk("R9 open row ignored while asleep", {strobes(), sd_cke, sd_addr}, {4'b1111, 1'b0, 12'h0});
        issue(4'd8, 2'd0, 12'h0, 10'h0, 1'b0, 1'b0, 12'h0);
        chk("R9 exit nop cke high", {strobes(), sd_cke}, {4'b0111, 1'b1});
        @(negedge clk);
        req_op = 4'd0; #1;
        chk("R9 ready back after exit", req_ready, 1);
        idle_cycle();
    endtask

    task automatic t_dqm_read();
        @(negedge clk);
        dm_valid = 1'b1; dm_is_read = 1'b1; dm_mask = 2'b10;
        @(posedge clk); #1;
        chk("R11 read mask one cycle later", sd_dqm, 2'b10);
        idle_cycle();
        chk("R12 dqm zero without mask", sd_dqm, 2'b00);
    endtask

    task automatic t_dqm_write();
        @(negedge clk);
        dm_valid = 1'b1; dm_is_read = 1'b0; dm_mask = 2'b01;
        @(posedge clk); #1;
        chk("R12 write mask not early c1", sd_dqm, 2'b00);
        idle_cycle();
        chk("R12 write mask not early c2", sd_dqm, 2'b00);
        idle_cycle();
        chk("R12 write mask in data cycle", sd_dqm, 2'b01);
        idle_cycle();
        chk("R12 write mask gone", sd_dqm, 2'b00);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_activate();
        t_read_write();
        t_precharge();
        t_misc_cmds();
        t_self_refresh();
        t_dqm_read();
        t_dqm_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule